// File: doc/BRIEF.md
# Memory-Reference Execute Sequencer

This block carries out the execute phase of a 16-bit accumulator machine for its seven memory-reference operations: bitwise AND into the accumulator, add into the accumulator with carry capture, load, store, unconditional jump, jump that saves a return address, and increment-then-skip-if-zero. A fetch/decode stage hands it a 3-bit operation code and a 12-bit effective address together with a one-cycle start request. The block latches both, then steps through up to three timing steps (T4, T5, T6). It drives a single-port memory through a shared address, a read strobe, a write strobe and write data. Read data is combinational, so it can be captured in the same step that issues the read.

The block owns the accumulator, the carry flag, the data register, the program counter and the address register. A memory word is never modified in place: an increment is a read into the data register, an increment there, and a write back. The last step of every operation returns the step counter to idle and raises a one-cycle completion pulse, so the surrounding control can begin the next instruction cycle.

Top module: `mri_exec_unit`

## Requirements
- R1: After reset the accumulator, carry flag and program counter are zero, the block is idle (busy_o low), and done_o, mem_rd_o and mem_wr_o are low.
- R2: Operation codes are 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ. A start in idle with codes 0 to 6 makes the block busy from the next cycle. A start with code 7 is ignored: there is no busy, no strobe, no done and no register change.
- R3: AND and LDA read the word at the effective address in T4 and complete in T5 with AC = AC & word or AC = word.
- R4: ADD reads in T4 and completes in T5 with AC = (AC + word) mod 2^16 and E = the carry out of bit 15.
- R5: Every operation other than ADD leaves E unchanged.
- R6: STA writes AC to the effective address in T4 and completes in that same step.
- R7: BUN loads PC with the effective address in T4 and completes in that step.
- R8: BSA writes the old PC, zero-extended, to the effective address in T4 and completes in T5 with PC = (effective address + 1) mod 4096.
- R9: ISZ reads in T4, increments in T5 and, in T6, writes the incremented word back to the effective address. If that word is zero, PC advances by one modulo 4096. The value 0xFFFF therefore wraps to zero and causes the skip.
- R10: done_o is high for exactly one cycle, the last step of each operation. busy_o falls after that cycle.
- R11: start_i is ignored while the block is busy.
- R12: mem_rd_o and mem_wr_o are never high together, and during any strobe mem_addr_o carries the effective address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin execution of opcode_i at ea_i |
| opcode_i | input | 3 | Decoded operation code |
| ea_i | input | 12 | Effective address |
| mem_rdata_i | input | 16 | Memory read data, valid in the same cycle as the address |
| mem_addr_o | output | 12 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe, written on the clock edge |
| mem_wdata_o | output | 16 | Memory write data |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag |
| pc_o | output | 12 | Program counter |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Last step of the current operation |

## Verification
A start accepted on edge k puts the block in T4 during the following cycle. The last step then falls one cycle later for STA and BUN, two cycles later for AND, ADD, LDA and BSA, and three cycles later for ISZ. Register results become visible on the first cycle after that last step. The bench model counts these steps for each operation and, in every step, samples done_o, both strobes, the address and the write data on the falling edge. It compares AC, E, PC and the written memory word in the first idle cycle that follows. The ignored-start cases are checked the same way: in the cycles where a wrong start could have acted, the bench confirms there is no strobe, no busy and no change in memory.

// File: rtl/mri_pkg.sv
package mri_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 12;

  typedef enum logic [1:0] {ST_T0, ST_T4, ST_T5, ST_T6} step_e;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_ADD  = 3'd1,
    OP_LDA  = 3'd2,
    OP_STA  = 3'd3,
    OP_BUN  = 3'd4,
    OP_BSA  = 3'd5,
    OP_ISZ  = 3'd6,
    OP_NONE = 3'd7
  } op_e;

  typedef enum logic [1:0] {AC_HOLD, AC_AND, AC_ADD, AC_LOAD} ac_sel_e;
  typedef enum logic [1:0] {WD_AC, WD_PC, WD_DR} wd_sel_e;

  typedef struct packed {
    logic    mem_rd;
    logic    mem_wr;
    wd_sel_e wd_sel;
    logic    dr_ld;
    logic    dr_inc;
    ac_sel_e ac_sel;
    logic    pc_ld_ar;
    logic    ar_inc;
    logic    pc_skip;
    logic    last;
  } ctrl_t;
endpackage

// File: rtl/mri_seq.sv
module mri_seq
  import mri_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  op_ok_i,
  input  logic  last_i,
  output step_e step_o,
  output logic  accept_o
);
  step_e step_q, step_d;

  assign accept_o = (step_q == ST_T0) && start_i && op_ok_i;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_T0: if (accept_o) step_d = ST_T4;
      ST_T4: step_d = last_i ? ST_T0 : ST_T5;
      ST_T5: step_d = last_i ? ST_T0 : ST_T6;
      ST_T6: step_d = ST_T0;
      default: step_d = ST_T0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_T0;
    else         step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/mri_ctrl.sv
module mri_ctrl
  import mri_pkg::*;
(
  input  op_e   op_i,
  input  step_e step_i,
  output ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (op_i)
      OP_AND, OP_ADD, OP_LDA: begin
        if (step_i == ST_T4) begin
          ctrl_o.mem_rd = 1'b1;
          ctrl_o.dr_ld  = 1'b1;
        end else if (step_i == ST_T5) begin
          ctrl_o.ac_sel = (op_i == OP_AND) ? AC_AND :
                          (op_i == OP_ADD) ? AC_ADD : AC_LOAD;
          ctrl_o.last   = 1'b1;
        end
      end
      OP_STA: if (step_i == ST_T4) begin
        ctrl_o.mem_wr = 1'b1;
        ctrl_o.wd_sel = WD_AC;
        ctrl_o.last   = 1'b1;
      end
      OP_BUN: if (step_i == ST_T4) begin
        ctrl_o.pc_ld_ar = 1'b1;
        ctrl_o.last     = 1'b1;
      end
      OP_BSA: begin
        if (step_i == ST_T4) begin
          ctrl_o.mem_wr = 1'b1;
          ctrl_o.wd_sel = WD_PC;
          ctrl_o.ar_inc = 1'b1;
        end else if (step_i == ST_T5) begin
          ctrl_o.pc_ld_ar = 1'b1;
          ctrl_o.last     = 1'b1;
        end
      end
      OP_ISZ: begin
        if (step_i == ST_T4) begin
          ctrl_o.mem_rd = 1'b1;
          ctrl_o.dr_ld  = 1'b1;
        end else if (step_i == ST_T5) begin
          ctrl_o.dr_inc = 1'b1;
        end else if (step_i == ST_T6) begin
          ctrl_o.mem_wr  = 1'b1;
          ctrl_o.wd_sel  = WD_DR;
          ctrl_o.pc_skip = 1'b1;
          ctrl_o.last    = 1'b1;
        end
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mri_datapath.sv
module mri_datapath
  import mri_pkg::*;
#(
  parameter int unsigned WORD_W = mri_pkg::WORD_W,
  parameter int unsigned ADDR_W = mri_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  ctrl_t             ctrl_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [WORD_W-1:0] ac_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              e_o,
  output logic [WORD_W-1:0] wdata_o
);
  localparam int unsigned PadW = WORD_W - ADDR_W;

  op_e               op_q;
  logic [ADDR_W-1:0] ar_q, pc_q;
  logic [WORD_W-1:0] ac_q, dr_q;
  logic              e_q;
  logic [WORD_W:0]   sum_w;

  assign sum_w = {1'b0, ac_q} + {1'b0, dr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_NONE;
      ar_q <= '0;
      pc_q <= '0;
      ac_q <= '0;
      dr_q <= '0;
      e_q  <= 1'b0;
    end else begin
      if (accept_i) begin
        op_q <= op_i;
        ar_q <= ea_i;
      end else if (ctrl_i.ar_inc) begin
        ar_q <= ar_q + 1'b1;
      end
      if (ctrl_i.dr_ld)       dr_q <= mem_rdata_i;
      else if (ctrl_i.dr_inc) dr_q <= dr_q + 1'b1;
      unique case (ctrl_i.ac_sel)
        AC_AND:  ac_q <= ac_q & dr_q;
        AC_ADD:  begin
          ac_q <= sum_w[WORD_W-1:0];
          e_q  <= sum_w[WORD_W];
        end
        AC_LOAD: ac_q <= dr_q;
        default: ac_q <= ac_q;
      endcase
      if (ctrl_i.pc_ld_ar)                       pc_q <= ar_q;
      else if (ctrl_i.pc_skip && (dr_q == '0))   pc_q <= pc_q + 1'b1;
    end
  end

  always_comb begin
    unique case (ctrl_i.wd_sel)
      WD_PC:   wdata_o = {{PadW{1'b0}}, pc_q};
      WD_DR:   wdata_o = dr_q;
      default: wdata_o = ac_q;
    endcase
  end

  assign op_o = op_q;
  assign ar_o = ar_q;
  assign ac_o = ac_q;
  assign pc_o = pc_q;
  assign e_o  = e_q;
endmodule

// File: rtl/mri_exec_unit.sv
module mri_exec_unit
  import mri_pkg::*;
#(
  parameter int unsigned WORD_W = mri_pkg::WORD_W,
  parameter int unsigned ADDR_W = mri_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        opcode_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [WORD_W-1:0] ac_o,
  output logic              e_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              busy_o,
  output logic              done_o
);
  step_e             step_w;
  logic              accept_w;
  ctrl_t             ctrl_w;
  op_e               op_w;
  logic [ADDR_W-1:0] ar_w;

  mri_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_ok_i  (opcode_i != 3'd7),
    .last_i   (ctrl_w.last),
    .step_o   (step_w),
    .accept_o (accept_w)
  );

  mri_ctrl u_ctrl (
    .op_i   (op_w),
    .step_i (step_w),
    .ctrl_o (ctrl_w)
  );

  mri_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept_w),
    .op_i        (op_e'(opcode_i)),
    .ea_i        (ea_i),
    .ctrl_i      (ctrl_w),
    .mem_rdata_i (mem_rdata_i),
    .op_o        (op_w),
    .ar_o        (ar_w),
    .ac_o        (ac_o),
    .pc_o        (pc_o),
    .e_o         (e_o),
    .wdata_o     (mem_wdata_o)
  );

  assign mem_addr_o = ar_w;
  assign mem_rd_o   = ctrl_w.mem_rd;
  assign mem_wr_o   = ctrl_w.mem_wr;
  assign busy_o     = (step_w != ST_T0);
  assign done_o     = ctrl_w.last;
endmodule

// File: rtl/mri_exec_unit_chk.sv
module mri_exec_unit_chk
  import mri_pkg::*;
#(
  parameter int unsigned ADDR_W = mri_pkg::ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              done_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              e_i,
  input logic [ADDR_W-1:0] pc_i,
  input op_e               op_i,
  input logic [ADDR_W-1:0] ar_i
);
  p_strobe_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!rd_i && !wr_i && !done_i));

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!done_i && !busy_i));

  p_e_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && op_i == OP_ADD) |=> $stable(e_i));

  p_bun_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_i == OP_BUN) |=> pc_i == $past(ar_i));

  p_bsa_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_i == OP_BSA) |=> pc_i == $past(ar_i));

  p_busy_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> (busy_i && $stable(op_i)));
endmodule

bind mri_exec_unit mri_exec_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy_o),
  .done_i (done_o),
  .rd_i   (mem_rd_o),
  .wr_i   (mem_wr_o),
  .e_i    (e_o),
  .pc_i   (pc_o),
  .op_i   (op_w),
  .ar_i   (ar_w)
);

// File: tb/tb_mri_exec_unit.sv
`timescale 1ns/1ps
module tb_mri_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opc = 3'd0;
  logic [11:0] ea = '0;
  logic [15:0] rdata;
  logic [11:0] maddr;
  logic        mrd, mwr, e, busy, done;
  logic [15:0] wdata, ac;
  logic [11:0] pc;

  logic [15:0] mem     [4096];
  logic [15:0] ref_mem [4096];
  logic [15:0] r_ac;
  logic        r_e;
  logic [11:0] r_pc;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mri_exec_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opc), .ea_i(ea),
    .mem_rdata_i(rdata), .mem_addr_o(maddr), .mem_rd_o(mrd), .mem_wr_o(mwr),
    .mem_wdata_o(wdata), .ac_o(ac), .e_o(e), .pc_o(pc), .busy_o(busy), .done_o(done)
  );

  assign rdata = mem[maddr];
  always @(posedge clk) if (mwr) mem[maddr] <= wdata;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int op);
    case (op)
      0, 2: return "R3";
      1: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  // poke: hold start high with a STA to poke_addr while busy
  task automatic run(int op, int a, bit poke, int poke_addr);
    int n;
    int wr_step;
    logic [15:0] exp_wd;
    logic [16:0] s17;
    string t;
    t = tag_of(op);
    n = (op == 3 || op == 4) ? 1 : (op == 6) ? 3 : 2;
    wr_step = (op == 3 || op == 5) ? 1 : (op == 6) ? 3 : 0;
    exp_wd = 16'h0;
    case (op)
      0: r_ac = r_ac & ref_mem[a];
      1: begin s17 = {1'b0, r_ac} + {1'b0, ref_mem[a]}; r_ac = s17[15:0]; r_e = s17[16]; end
      2: r_ac = ref_mem[a];
      3: begin exp_wd = r_ac; ref_mem[a] = r_ac; end
      4: r_pc = 12'(a);
      5: begin exp_wd = {4'h0, r_pc}; ref_mem[a] = exp_wd; r_pc = 12'(a + 1); end
      default: begin
        ref_mem[a] = ref_mem[a] + 16'h1; exp_wd = ref_mem[a];
        if (ref_mem[a] == 16'h0) r_pc = r_pc + 12'h1;
      end
    endcase
    @(negedge clk);
    start = 1'b1; opc = 3'(op); ea = 12'(a);
    @(posedge clk);
    @(negedge clk);
    if (poke) begin opc = 3'd3; ea = 12'(poke_addr); end
    else start = 1'b0;
    for (int s = 1; s <= n; s++) begin
      if (s == n) start = 1'b0;
      chk("R10", int'(done), int'(s == n));
      chk("R10", int'(busy), 1);
      chk("R12", int'(mrd && mwr), 0);
      chk(t, int'(mwr), int'(s == wr_step));
      if (mwr || mrd) chk("R12", int'(maddr), a);
      if (s == wr_step) chk(t, int'(wdata), int'(exp_wd));
      @(posedge clk);
      @(negedge clk);
    end
    chk("R10", int'(busy), 0);
    chk("R10", int'(done), 0);
    chk(t, int'(ac), int'(r_ac));
    chk((op == 1) ? "R4" : "R5", int'(e), int'(r_e));
    chk(t, int'(pc), int'(r_pc));
    chk(t, int'(mem[a]), int'(ref_mem[a]));
    if (poke) chk("R11", int'(mem[poke_addr]), int'(ref_mem[poke_addr]));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 16'(i * 40503) ^ 16'h5a5a;
    end
    mem[10] = 16'h00FF; mem[11] = 16'hF0F0; mem[12] = 16'hFFFF;
    mem[13] = 16'h0001; mem[20] = 16'hFFFF; mem[21] = 16'h0005;
    mem[40] = 16'h1234;
    for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
    r_ac = '0; r_e = 1'b0; r_pc = '0;

    repeat (3) @(negedge clk);
    chk("R1", int'(ac), 0);
    chk("R1", int'(e), 0);
    chk("R1", int'(pc), 0);
    chk("R1", int'(busy), 0);
    chk("R1", int'(mrd | mwr | done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(2, 10, 0, 0);      // LDA 0x00FF
    run(0, 11, 0, 0);      // AND -> 0x00F0
    run(1, 12, 0, 0);      // ADD 0xFFFF -> carry set
    run(2, 13, 0, 0);      // LDA 1, E kept
    run(1, 13, 0, 0);      // ADD 1 -> carry clear
    run(3, 30, 0, 0);      // STA
    run(4, 100, 0, 0);     // BUN
    run(5, 4095, 0, 0);    // BSA wraps PC to 0
    run(6, 20, 0, 0);      // ISZ 0xFFFF -> skip
    run(6, 21, 0, 0);      // ISZ no skip
    run(6, 20, 0, 0);      // ISZ 0 -> 1 no skip
    run(6, 12, 1, 40);     // start held during busy
    run(5, 50, 1, 40);
    run(2, 12, 0, 0);
    run(1, 12, 0, 0);

    // R2: opcode 7 ignored
    @(negedge clk);
    start = 1'b1; opc = 3'd7; ea = 12'd40;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R2", int'(busy), 0);
      chk("R2", int'(mrd | mwr | done), 0);
      @(negedge clk);
    end
    chk("R2", int'(ac), int'(r_ac));
    chk("R2", int'(pc), int'(r_pc));
    chk("R2", int'(mem[40]), int'(ref_mem[40]));

    for (int i = 0; i < 28; i++) begin
      run(i % 7, 200 + (i * 37) % 64, (i % 5) == 0, 41);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule